// File: doc/BRIEF.md
# Dual-Line Edge-Triggered Interrupt Bank

This block collects up to 32 asynchronous event inputs (24 by default) and reports them on two independent active-low interrupt lines. Each input is brought into the clock domain by a two-flop synchroniser. A per-source edge detector then fires on a rising edge, a falling edge, both or neither, as chosen by a single edge-select register that both lines share. Each line keeps its own status register and its own mask register. An event therefore latches a status bit on both lines, and software on each line decides separately which sources may pull its line low.

Software reaches the registers over a simple synchronous byte-wide bus. Address bits [5:3] pick a register group and bits [2:0] pick a byte inside it:

| Group | Address |
|---|---|
| line 0 status | 0x00 |
| line 1 status | 0x08 |
| line 0 mask | 0x10 |
| line 1 mask | 0x18 |
| force | 0x20 |
| edge select | 0x28 |
| control | 0x30 |

The control byte holds two bits. Bit 0 selects clear-on-read, in place of write-one-to-clear. Bit 1 enables a one-deep buffer, which holds an event that arrives for a source that is already pending. Writing the force register sets status bits directly, for testing. Read data is registered and appears on the cycle after the read strobe.

Top module: `dual_irq_bank`

## Requirements
- R1: After reset, every mask bit of both lines is 1, every status bit is 0, every edge-select bit is 0, the control byte reads 0x00, and both interrupt lines are high.
- R2: The edge field of source i is bits (i mod 4)*2+1 and (i mod 4)*2 of edge-select byte i/4. The upper bit enables rising-edge detection and the lower bit enables falling-edge detection. A detected edge sets the source's status bit, which sits at bit i mod 8 of status byte i/8.
- R3: A source whose two edge bits are both 0 never sets a status bit on either line, whatever its input does.
- R4: One event sets the status bit on both lines. Clearing it on one line leaves the other line's bit set. The single edge-select register governs detection for both lines.
- R5: Interrupt line L (irqN[L]) is low exactly when some status bit of line L has a 0 in the same position of line L's mask. A mask bit of 1 blocks its source on that line only.
- R6: With control bit 0 cleared, writing a status byte clears the bits written as 1 and leaves the others unchanged.
- R7: With control bit 0 set, reading a status byte returns its bits and clears them. A write to a status byte then has no effect.
- R8: With control bit 1 set, an edge on a source that is already pending is held. After the first clear the status bit comes back, so two clears are needed. With control bit 1 cleared, the extra edge is lost.
- R9: Writing 1 to a bit of the force register (address group 0x20) sets the matching status bit on both lines, as if an edge had occurred. Reads of the force register return 0.
- R10: Status and mask bits at positions at or above the source count read as 0 and cannot be set, even by the force register.
- R11: An edge detected in the same cycle that clears its status bit wins, so the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| srcIn | input | NUM_SRC | Asynchronous event inputs |
| busSel | input | 1 | Bus access strobe, one cycle per access |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 6 | Byte address: group in [5:3], byte in [2:0] |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, registered, valid the cycle after a read |
| irqN | output | 2 | Active-low interrupt lines, bit L for line L |

## Verification
When an input changes just before a clock edge, the status bit and the interrupt line respond at the third edge after the change: two synchroniser stages, then the edge/status register. The bench therefore waits three rising edges after each input change and samples only at the following falling edge. Read data is due one edge after the read strobe. The scoreboard queues each expected byte when the driver issues the read, and the monitor pops and compares it at the falling edge after the capturing edge. A write acts at the edge that captures it, so line and status checks follow a write by at least one full cycle. The edge-wins case places the clearing write on exactly the edge where the synchronised rise is detected.

// File: rtl/dual_irq_pkg.sv
package dual_irq_pkg;
  localparam int ADDR_W = 6;
  localparam int BYTE_SEL_W = 3;
  localparam int MAX_SRC = 8 * (1 << BYTE_SEL_W) / 2;

  typedef enum logic [2:0] {
    RG_STAT0 = 3'd0,
    RG_STAT1 = 3'd1,
    RG_MASK0 = 3'd2,
    RG_MASK1 = 3'd3,
    RG_FORCE = 3'd4,
    RG_EDGE  = 3'd5,
    RG_CTRL  = 3'd6,
    RG_NONE  = 3'd7
  } region_e;

  typedef struct packed {
    logic                  rd;
    logic                  wr;
    region_e               region;
    logic [BYTE_SEL_W-1:0] byteIdx;
    logic [7:0]            wdata;
    logic                  clrOnRead;
    logic                  pendEn;
  } busStrobe_t;
endpackage

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
  import dual_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output busStrobe_t        strobe
);
  logic    corQ;
  logic    pendQ;
  region_e region;

  assign region = region_e'(busAddr[ADDR_W-1:BYTE_SEL_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      corQ  <= 1'b0;
      pendQ <= 1'b0;
    end else if (busSel && busWrite && region == RG_CTRL && busAddr[BYTE_SEL_W-1:0] == '0) begin
      corQ  <= busWdata[0];
      pendQ <= busWdata[1];
    end
  end

  always_comb begin
    strobe.rd        = busSel & ~busWrite;
    strobe.wr        = busSel & busWrite;
    strobe.region    = region;
    strobe.byteIdx   = busAddr[BYTE_SEL_W-1:0];
    strobe.wdata     = busWdata;
    strobe.clrOnRead = corQ;
    strobe.pendEn    = pendQ;
  end

  // R7: a control write takes effect at the edge that captures it
  assert_ctrl_update_R7: assert property (@(posedge clk) disable iff (rst)
    $past(busSel && busWrite && region == RG_CTRL && busAddr[BYTE_SEL_W-1:0] == '0)
      |-> (strobe.clrOnRead == $past(busWdata[0]) && strobe.pendEn == $past(busWdata[1])));
endmodule

// File: rtl/dual_irq_datapath.sv
module dual_irq_datapath
  import dual_irq_pkg::*;
#(
  parameter int NUM_SRC     = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] srcIn,
  input  busStrobe_t         strobe,
  output logic [7:0]         busRdata,
  output logic [1:0]         irqN
);
  localparam int EDGE_W = 2 * NUM_SRC;
  localparam int LINES  = 2;

  logic [NUM_SRC-1:0] syncQ [SYNC_STAGES];
  logic [NUM_SRC-1:0] prevQ;
  logic [NUM_SRC-1:0] syncLast;
  logic [EDGE_W-1:0]  edgeSel;
  logic [NUM_SRC-1:0] edgeEvt;
  logic [NUM_SRC-1:0] byteMask;
  logic [NUM_SRC-1:0] wdataRep;
  logic [NUM_SRC-1:0] forceVec;
  logic [NUM_SRC-1:0] setVec;
  logic [EDGE_W-1:0]  edgeByteMask;
  logic [EDGE_W-1:0]  edgeWdataRep;
  logic [LINES-1:0][NUM_SRC-1:0] statusQ;
  logic [LINES-1:0][NUM_SRC-1:0] bufQ;
  logic [LINES-1:0][NUM_SRC-1:0] maskQ;
  logic [LINES-1:0][NUM_SRC-1:0] clrVec;
  logic [LINES-1:0] statHit;
  logic [LINES-1:0] maskHit;
  logic [7:0]       readByte;

  // input synchroniser and edge history
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= srcIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign syncLast = syncQ[SYNC_STAGES-1];

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      edgeEvt[i] = (syncLast[i] & ~prevQ[i] & edgeSel[2*i+1]) |
                   (~syncLast[i] & prevQ[i] & edgeSel[2*i]);
    end
  end

  // byte lane selection for bus writes
  always_comb begin
    for (int b = 0; b < NUM_SRC; b++) begin
      byteMask[b] = (b / 8) == int'(strobe.byteIdx);
      wdataRep[b] = strobe.wdata[b % 8];
    end
    for (int b = 0; b < EDGE_W; b++) begin
      edgeByteMask[b] = (b / 8) == int'(strobe.byteIdx);
      edgeWdataRep[b] = strobe.wdata[b % 8];
    end
  end

  assign statHit[0] = strobe.region == RG_STAT0;
  assign statHit[1] = strobe.region == RG_STAT1;
  assign maskHit[0] = strobe.region == RG_MASK0;
  assign maskHit[1] = strobe.region == RG_MASK1;

  assign forceVec = (strobe.wr && strobe.region == RG_FORCE) ? (byteMask & wdataRep) : '0;
  assign setVec   = edgeEvt | forceVec;

  always_comb begin
    for (int l = 0; l < LINES; l++) begin
      if (strobe.rd && statHit[l] && strobe.clrOnRead)
        clrVec[l] = byteMask;
      else if (strobe.wr && statHit[l] && !strobe.clrOnRead)
        clrVec[l] = byteMask & wdataRep;
      else
        clrVec[l] = '0;
    end
  end

  // edge select register, shared by both lines
  always_ff @(posedge clk) begin
    if (rst) begin
      edgeSel <= '0;
    end else if (strobe.wr && strobe.region == RG_EDGE) begin
      edgeSel <= (edgeSel & ~edgeByteMask) | (edgeWdataRep & edgeByteMask);
    end
  end

  // per-line status, pending buffer and mask
  always_ff @(posedge clk) begin
    if (rst) begin
      statusQ <= '0;
      bufQ    <= '0;
      maskQ   <= '1;
    end else begin
      for (int l = 0; l < LINES; l++) begin
        statusQ[l] <= (clrVec[l] & (setVec | bufQ[l])) |
                      (~clrVec[l] & (statusQ[l] | setVec));
        bufQ[l]    <= (clrVec[l] & setVec & bufQ[l] & {NUM_SRC{strobe.pendEn}}) |
                      (~clrVec[l] & (bufQ[l] | (setVec & statusQ[l] & {NUM_SRC{strobe.pendEn}})));
        if (strobe.wr && maskHit[l])
          maskQ[l] <= (maskQ[l] & ~byteMask) | (wdataRep & byteMask);
      end
    end
  end

  function automatic logic [7:0] pickSrc(input logic [NUM_SRC-1:0] v, input logic [BYTE_SEL_W-1:0] k);
    logic [7:0] r;
    r = '0;
    for (int j = 0; j < 8; j++) begin
      if (int'(k) * 8 + j < NUM_SRC) r[j] = v[int'(k) * 8 + j];
    end
    return r;
  endfunction

  function automatic logic [7:0] pickEdge(input logic [EDGE_W-1:0] v, input logic [BYTE_SEL_W-1:0] k);
    logic [7:0] r;
    r = '0;
    for (int j = 0; j < 8; j++) begin
      if (int'(k) * 8 + j < EDGE_W) r[j] = v[int'(k) * 8 + j];
    end
    return r;
  endfunction

  always_comb begin
    case (strobe.region)
      RG_STAT0: readByte = pickSrc(statusQ[0], strobe.byteIdx);
      RG_STAT1: readByte = pickSrc(statusQ[1], strobe.byteIdx);
      RG_MASK0: readByte = pickSrc(maskQ[0], strobe.byteIdx);
      RG_MASK1: readByte = pickSrc(maskQ[1], strobe.byteIdx);
      RG_EDGE:  readByte = pickEdge(edgeSel, strobe.byteIdx);
      RG_CTRL:  readByte = (strobe.byteIdx == '0) ? {6'b0, strobe.pendEn, strobe.clrOnRead} : 8'h00;
      default:  readByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) busRdata <= '0;
    else if (strobe.rd) busRdata <= readByte;
  end

  generate
    for (genvar l = 0; l < LINES; l++) begin : gLine
      assign irqN[l] = ~|(statusQ[l] & ~maskQ[l]);

      // R1: state right after reset
      assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (maskQ[l] == '1 && statusQ[l] == '0));

      // R3: a status bit only rises from a detected event, a force or a held event
      assert_set_source_R3: assert property (@(posedge clk) disable iff (rst)
        (statusQ[l] & ~$past(statusQ[l]) & ~$past(setVec | bufQ[l])) == '0);

      // R11: an event always leaves its bit set, even under a clear
      assert_edge_wins_R11: assert property (@(posedge clk) disable iff (rst)
        ($past(setVec) & ~statusQ[l]) == '0);

      // R8: a held event reasserts the bit when it is cleared
      assert_pend_release_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(clrVec[l] & bufQ[l]) & ~statusQ[l]) == '0);
    end
  endgenerate
endmodule

// File: rtl/dual_irq_bank.sv
module dual_irq_bank
  import dual_irq_pkg::*;
#(
  parameter int NUM_SRC     = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [5:0]         busAddr,
  input  logic [7:0]         busWdata,
  output logic [7:0]         busRdata,
  output logic [1:0]         irqN
);
  busStrobe_t strobe;

  initial begin
    assert (NUM_SRC >= 1 && NUM_SRC <= MAX_SRC && SYNC_STAGES >= 2)
      else $error("dual_irq_bank: parameter out of range");
  end

  dual_irq_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .strobe   (strobe)
  );

  dual_irq_datapath #(
    .NUM_SRC     (NUM_SRC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .srcIn    (srcIn),
    .strobe   (strobe),
    .busRdata (busRdata),
    .irqN     (irqN)
  );
endmodule

// File: tb/dual_irq_bank_tb.sv
module dual_irq_bank_tb;
  localparam int NSRC = 24;
  localparam logic [5:0] A_ST0 = 6'h00, A_ST1 = 6'h08, A_MK0 = 6'h10, A_MK1 = 6'h18,
                         A_FRC = 6'h20, A_EDG = 6'h28, A_CTL = 6'h30;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] srcIn = '0;
  logic            busSel = 1'b0;
  logic            busWrite = 1'b0;
  logic [5:0]      busAddr = '0;
  logic [7:0]      busWdata = '0;
  logic [7:0]      busRdata;
  logic [1:0]      irqN;

  int    nChecks = 0;
  int    nFails = 0;
  logic  rdIssuedD = 1'b0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #10 clk = ~clk;

  dual_irq_bank #(.NUM_SRC(NSRC)) u_dut (
    .clk(clk), .rst(rst), .srcIn(srcIn), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqN(irqN)
  );

  // monitor: compare registered read data against the scoreboard
  always @(posedge clk) rdIssuedD <= busSel & ~busWrite;

  always @(negedge clk) begin
    if (rdIssuedD && expQ.size() > 0) begin
      logic [7:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      nChecks++;
      if (busRdata !== e) begin
        nFails++;
        $display("FAIL %s: read data %h expected %h", t, busRdata, e);
      end
    end
  end

  task automatic busWr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [5:0] a, input logic [7:0] e, input string t);
    expQ.push_back(e);
    tagQ.push_back(t);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic srcDrive(input int i, input logic v);
    @(negedge clk);
    srcIn[i] = v;
    repeat (3) @(posedge clk);
  endtask

  task automatic irqChk(input logic [1:0] e, input string t);
    @(negedge clk);
    nChecks++;
    if (irqN !== e) begin
      nFails++;
      $display("FAIL %s: irqN %b expected %b", t, irqN, e);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finishRun();
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    irqChk(2'b11, "R1 lines idle");
    busRd(A_MK0, 8'hFF, "R1 mask0 byte0");
    busRd(A_MK1 + 6'd2, 8'hFF, "R1 mask1 byte2");
    busRd(A_ST0, 8'h00, "R1 status0 byte0");
    busRd(A_EDG, 8'h00, "R1 edge byte0");
    busRd(A_CTL, 8'h00, "R1 control");

    // R3: no edge enabled, toggling has no effect
    srcDrive(0, 1'b1);
    srcDrive(0, 1'b0);
    busRd(A_ST0, 8'h00, "R3 status0 disabled source");
    busRd(A_ST1, 8'h00, "R3 status1 disabled source");

    // R2: src0 rising, src1 falling, src2 rising
    busWr(A_EDG, 8'h26);
    srcDrive(0, 1'b1);
    busRd(A_ST0, 8'h01, "R2 rising sets line0");
    busRd(A_ST1, 8'h01, "R4 rising sets line1");
    irqChk(2'b11, "R5 all masked");
    busWr(A_MK0, 8'hFE);
    irqChk(2'b10, "R5 line0 unmasked only");

    // R6 write-one-to-clear
    busWr(A_ST0, 8'h01);
    busRd(A_ST0, 8'h00, "R6 w1c clears line0");
    busRd(A_ST1, 8'h01, "R4 line1 unaffected");
    irqChk(2'b11, "R5 line0 released");

    // R2 falling edge on src1
    srcDrive(1, 1'b1);
    busRd(A_ST0, 8'h00, "R2 rise ignored on fall-only source");
    srcDrive(1, 1'b0);
    busRd(A_ST0, 8'h02, "R2 falling sets bit1");
    busRd(A_ST1, 8'h03, "R4 line1 accumulates");

    // R7 clear-on-read
    busWr(A_CTL, 8'h01);
    busRd(A_CTL, 8'h01, "R7 control readback");
    busRd(A_ST0, 8'h02, "R7 first read");
    busRd(A_ST0, 8'h00, "R7 read cleared");
    busWr(A_ST1, 8'h03);
    busRd(A_ST1, 8'h03, "R7 write ignored");
    busRd(A_ST1, 8'h00, "R7 line1 read cleared");

    // R11 edge wins over coincident clear
    busWr(A_CTL, 8'h00);
    srcDrive(2, 1'b1);
    busRd(A_ST0, 8'h04, "R11 set before");
    srcDrive(2, 1'b0);
    @(negedge clk);
    srcIn[2] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = A_ST0; busWdata = 8'h04;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
    busRd(A_ST0, 8'h04, "R11 edge kept bit");
    busWr(A_ST0, 8'h04);
    busRd(A_ST0, 8'h00, "R11 plain clear");

    // R8 pending buffer
    busWr(A_CTL, 8'h03);
    busWr(A_EDG + 6'd2, 8'h03);
    srcDrive(8, 1'b1);
    srcDrive(8, 1'b0);
    busRd(A_ST0 + 6'd1, 8'h01, "R8 first read");
    busRd(A_ST0 + 6'd1, 8'h01, "R8 held event");
    busRd(A_ST0 + 6'd1, 8'h00, "R8 drained");
    busWr(A_CTL, 8'h01);
    busWr(A_EDG + 6'd2, 8'h0F);
    srcDrive(9, 1'b1);
    srcDrive(9, 1'b0);
    busRd(A_ST0 + 6'd1, 8'h02, "R8 no buffer first read");
    busRd(A_ST0 + 6'd1, 8'h00, "R8 no buffer extra lost");

    // R9 force
    busWr(A_FRC + 6'd2, 8'h80);
    busRd(A_ST0 + 6'd2, 8'h80, "R9 force line0");
    busRd(A_ST1 + 6'd2, 8'h80, "R9 force line1");
    busRd(A_FRC + 6'd2, 8'h00, "R9 force reads zero");

    // R10 beyond the source count
    busWr(A_FRC + 6'd3, 8'hFF);
    busWr(A_MK0 + 6'd3, 8'h00);
    busRd(A_ST0 + 6'd3, 8'h00, "R10 status byte3");
    busRd(A_MK0 + 6'd3, 8'h00, "R10 mask byte3");
    irqChk(2'b11, "R10 no line from absent sources");
    busRd(A_EDG + 6'd2, 8'h0F, "R2 edge byte2 readback");

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule